// File: doc/BRIEF.md
# Programmable Digit Sequencer Core

This block is a very small stored-program controller. It drives a 4-bit digit bus, and a single mode input picks between two digit sequences. It holds sixteen 6-bit instruction words and has a 4-bit program counter and a 4-bit output register. It completes one instruction on every clock edge.

The instruction set has three kinds of instruction:

- **Emit**: places its operand on the digit bus.
- **Jump**: moves the program counter to its operand.
- **Conditional jump**: moves the program counter to its operand when the mode input is high, and otherwise falls through to the next word.

At power-up the store holds a nine-word program. With the mode input low, that program emits the digits 3 2 4 8 5 6 1. With the mode input high, it emits only the last four digits, 8 5 6 1.

A program port can replace any word. It takes effect only while reset is held, so loading happens before execution starts and cannot disturb a running program.

Top module: `seq_pgm_cpu`

## Requirements
- R1: An instruction word has the opcode in bits [5:4] and the operand in bits [3:0]. Opcode 00 is an unconditional jump, 01 is a conditional jump, and both 10 and 11 decode as emit.
- R2: While `rst_n` is low, the program counter and `dout_o` are 0. Execution starts with the word at address 0 on the first clock edge after release.
- R3: An emit word puts its operand on `dout_o` at the next clock edge and advances the program counter by one. This holds for opcode 10 and for opcode 11.
- R4: An unconditional jump loads its operand into the program counter and leaves `dout_o` unchanged.
- R5: A conditional jump loads its operand into the program counter when `loc_i` is 1 at that edge. When `loc_i` is 0, it advances the program counter by one. In both cases `dout_o` is unchanged.
- R6: Exactly one word executes per clock edge, and an increment from address 15 wraps to address 0.
- R7: The power-up store holds the following program. Addresses 9 to 15 hold 0x00, which is a jump to address 0.

  | Address | Word |
  |---|---|
  | 0 | 0x14 |
  | 1 | 0x23 |
  | 2 | 0x22 |
  | 3 | 0x24 |
  | 4 | 0x28 |
  | 5 | 0x25 |
  | 6 | 0x26 |
  | 7 | 0x21 |
  | 8 | 0x00 |

  With `loc_i`=0, `dout_o` repeats 3 2 4 8 5 6 1 with a period of 9 cycles. With `loc_i`=1, it repeats 8 5 6 1 with a period of 6 cycles.
- R8: A clock edge with `pgm_we_i` high and `rst_n` low writes `pgm_data_i` to address `pgm_addr_i`. With `rst_n` high, the program port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_i | input | 1 | Mode input, tested by conditional jumps |
| pgm_we_i | input | 1 | Program write enable, honoured only in reset |
| pgm_addr_i | input | 4 | Program write address |
| pgm_data_i | input | 6 | Program word to write |
| dout_o | output | 4 | Digit output register |

## Verification
The bench builds the block with its default operand width of 4. That gives a 16-word store, and the program counter can therefore reach its wrap from address 15 back to 0. A custom program loaded through the program port uses both emit opcodes, both outcomes of the conditional jump and that wrap. The power-up program is traced in both modes, and the traces are compared with the digit streams that dedicated sequencing logic would produce, allowing for the two extra jump cycles per pass.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int OPC_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_JMP  = 2'b00,
        OP_JC   = 2'b01,
        OP_OUT  = 2'b10,
        OP_OUT2 = 2'b11
    } opcode_e;

    // Power-up program: conditional jump to 4, seven emits, jump to 0.
    function automatic logic [OPC_W-1:0] boot_op(input int unsigned idx);
        case (idx)
            0:                      return OP_JC;
            1, 2, 3, 4, 5, 6, 7:    return OP_OUT;
            default:                return OP_JMP;
        endcase
    endfunction

    function automatic int unsigned boot_arg(input int unsigned idx);
        case (idx)
            0:       return 4;
            1:       return 3;
            2:       return 2;
            3:       return 4;
            4:       return 8;
            5:       return 5;
            6:       return 6;
            7:       return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/seq_imem.sv
module seq_imem
    import seq_pkg::*;
#(
    parameter int OPND_W = 4,
    localparam int WORD_W = OPC_W + OPND_W,
    localparam int DEPTH  = 2 ** OPND_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [OPND_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [OPND_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Power-up contents of the store.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] = {boot_op(i), OPND_W'(boot_arg(i))};
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Asynchronous read, so each word is fetched and executed in one cycle.
    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic             loc,
    output logic             pc_ld,
    output logic             pc_inc,
    output logic             out_ld
);

    always_comb begin
        out_ld = opc[1];
        pc_ld  = ~opc[1] & (~opc[0] | loc);
        pc_inc = ~pc_ld;
    end

endmodule

// File: rtl/seq_pgm_cpu.sv
module seq_pgm_cpu
    import seq_pkg::*;
#(
    parameter int OPND_W = 4,
    localparam int WORD_W = OPC_W + OPND_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_i,
    input  logic              pgm_we_i,
    input  logic [OPND_W-1:0] pgm_addr_i,
    input  logic [WORD_W-1:0] pgm_data_i,
    output logic [OPND_W-1:0] dout_o
);

    typedef struct packed {
        logic [OPND_W-1:0] pc;
        logic [OPND_W-1:0] dout;
    } cpu_st_t;

    cpu_st_t st_d, st_q;

    logic [WORD_W-1:0] instr_w;
    logic [OPND_W-1:0] arg_w;
    logic              pc_ld_w, pc_inc_w, out_ld_w;

    seq_imem #(.OPND_W(OPND_W)) i_imem (
        .clk     (clk),
        .wr_en   (pgm_we_i & ~rst_n),
        .wr_addr (pgm_addr_i),
        .wr_data (pgm_data_i),
        .rd_addr (st_q.pc),
        .rd_data (instr_w)
    );

    assign arg_w = instr_w[OPND_W-1:0];

    seq_ctrl i_ctrl (
        .opc    (instr_w[WORD_W-1 -: OPC_W]),
        .loc    (loc_i),
        .pc_ld  (pc_ld_w),
        .pc_inc (pc_inc_w),
        .out_ld (out_ld_w)
    );

    always_comb begin
        st_d = st_q;
        if (out_ld_w) begin
            st_d.dout = arg_w;
        end
        if (pc_ld_w) begin
            st_d.pc = arg_w;
        end else if (pc_inc_w) begin
            st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.dout;

endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
    parameter int OPND_W = 4,
    localparam int WORD_W = 2 + OPND_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loc,
    input logic [WORD_W-1:0] instr,
    input logic [OPND_W-1:0] pc,
    input logic [OPND_W-1:0] dout
);

    logic [1:0]        opc;
    logic [OPND_W-1:0] arg;
    assign opc = instr[WORD_W-1 -: 2];
    assign arg = instr[OPND_W-1:0];

    // R2: registers held clear during reset
    a_r2_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (pc == '0 && dout == '0));

    // R3: emit loads the operand onto the output
    a_r3_emit_value: assert property (@(posedge clk) disable iff (!rst_n)
        opc[1] |=> dout == $past(arg));

    // R3, R6: emit advances the program counter, wrapping at the top
    a_r3_emit_advance: assert property (@(posedge clk) disable iff (!rst_n)
        opc[1] |=> pc == OPND_W'($past(pc) + 1'b1));

    // R4: jump reaches its target and keeps the output
    a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        opc == 2'b00 |=> (pc == $past(arg) && $stable(dout)));

    // R5: conditional jump taken when the mode input is high
    a_r5_jc_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 2'b01 && loc) |=> (pc == $past(arg) && $stable(dout)));

    // R5: conditional jump falls through when the mode input is low
    a_r5_jc_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == 2'b01 && !loc) |=> (pc == OPND_W'($past(pc) + 1'b1) && $stable(dout)));

endmodule

bind seq_pgm_cpu seq_chk #(.OPND_W(OPND_W)) i_seq_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .loc   (loc_i),
    .instr (instr_w),
    .pc    (st_q.pc),
    .dout  (dout_o)
);

// File: tb/test_seq_pgm_cpu.sv
`timescale 1ns/1ps
module test_seq_pgm_cpu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loc = 1'b0;
    logic       pgm_we = 1'b0;
    logic [3:0] pgm_addr = '0;
    logic [5:0] pgm_data = '0;
    logic [3:0] dout;

    int n_run = 0;
    int n_fail = 0;

    logic [5:0] ref_mem [16];
    int ref_pc = 0;
    int ref_dout = 0;

    always #4 clk = ~clk;

    seq_pgm_cpu i_seq_pgm_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_i      (loc),
        .pgm_we_i   (pgm_we),
        .pgm_addr_i (pgm_addr),
        .pgm_data_i (pgm_data),
        .dout_o     (dout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Reference model: execute the word at ref_pc, then compare after the edge.
    task automatic step(input logic l, output int seen);
        logic [5:0] w;
        string tag;
        loc = l;
        w = ref_mem[ref_pc];
        if (w[5]) begin
            ref_dout = int'(w[3:0]);
            tag = (ref_pc == 15) ? "R6 emit+wrap" : (w[4] ? "R3 emit op11" : "R3 emit op10");
            ref_pc = (ref_pc + 1) % 16;
        end else if (!w[4]) begin
            ref_pc = int'(w[3:0]);
            tag = "R4 jump";
        end else if (l) begin
            ref_pc = int'(w[3:0]);
            tag = "R5 cjump taken";
        end else begin
            ref_pc = (ref_pc + 1) % 16;
            tag = "R5 cjump fallthrough";
        end
        @(posedge clk);
        @(negedge clk);
        seen = int'(dout);
        chk(tag, seen, ref_dout);
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_pc = 0;
        ref_dout = 0;
        #1;
        chk("R2 clear on reset", int'(dout), 0);
    endtask

    task automatic wr_word(input int a, input logic [5:0] d);
        pgm_we = 1'b1;
        pgm_addr = 4'(a);
        pgm_data = d;
        @(negedge clk);
        pgm_we = 1'b0;
        ref_mem[a] = d;
    endtask

    task automatic leave_reset();
        @(negedge clk);
        rst_n = 1'b1;
        chk("R2 clear after release", int'(dout), 0);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        int seen;
        int exp_nl [11] = '{0, 3, 2, 4, 8, 5, 6, 1, 1, 1, 3};
        int exp_lc [8]  = '{0, 8, 5, 6, 1, 1, 1, 8};

        for (int i = 0; i < 16; i++) ref_mem[i] = 6'h00;
        ref_mem[0] = 6'h14; ref_mem[1] = 6'h23; ref_mem[2] = 6'h22;
        ref_mem[3] = 6'h24; ref_mem[4] = 6'h28; ref_mem[5] = 6'h25;
        ref_mem[6] = 6'h26; ref_mem[7] = 6'h21; ref_mem[8] = 6'h00;

        // R2: reset state from time zero
        repeat (3) @(negedge clk);
        chk("R2 reset state", int'(dout), 0);
        leave_reset();

        // R7: power-up program, non-local mode, period 9
        for (int k = 0; k < 11; k++) begin
            step(1'b0, seen);
            chk("R7 non-local trace", seen, exp_nl[k]);
        end

        // R7: local mode from a fresh start, period 6
        enter_reset();
        leave_reset();
        for (int k = 0; k < 8; k++) begin
            step(1'b1, seen);
            chk("R7 local trace", seen, exp_lc[k]);
        end

        // R8: program writes while running are ignored
        pgm_we = 1'b1; pgm_addr = 4'd1; pgm_data = 6'h2F;
        step(1'b0, seen);
        pgm_addr = 4'd4; pgm_data = 6'h2E;
        step(1'b0, seen);
        pgm_we = 1'b0;
        enter_reset();
        leave_reset();
        for (int k = 0; k < 9; k++) begin
            step(1'b0, seen);
            chk("R8 run-time write ignored", seen, exp_nl[k]);
        end

        // R8: load a custom program during reset
        enter_reset();
        wr_word(0, 6'h2A);   // emit 10, opcode 10
        wr_word(1, 6'h35);   // emit 5, opcode 11
        wr_word(2, 6'h15);   // cjump to 5
        wr_word(3, 6'h2F);   // emit 15
        wr_word(4, 6'h00);   // jump 0
        wr_word(5, 6'h20);   // emit 0
        wr_word(6, 6'h0F);   // jump 15
        wr_word(15, 6'h27);  // emit 7, then wrap to 0
        chk("R2 held during load", int'(dout), 0);
        leave_reset();
        for (int k = 0; k < 40; k++) begin
            step(((k / 3) % 2) == 1, seen);
        end

        // R2: asynchronous reset in mid-run, then the custom program persists
        enter_reset();
        leave_reset();
        step(1'b0, seen);
        chk("R8 custom word at 0", seen, 10);
        step(1'b1, seen);
        chk("R1 opcode 11 emits", seen, 5);

        summary();
    end

endmodule